// File: doc/BRIEF.md
# Adaptive Peak Tracker and Bit Slicer

This block sits in the receive path of a two-level FM data modem, after the discriminator output has been filtered and digitized. It keeps two running estimates, one for the positive signal excursions and one for the negative excursions. The midpoint of the two estimates is the decision level, so any DC offset in the input cancels out. At each mid-bit strobe from the clock recovery loop, the current sample is compared with that level to give one received bit. The level is also shifted from bit to bit to offset intersymbol interference. The size of that shift depends on the selected Gaussian filter bandwidth.

A control input picks how fast the estimates move, through three states:
- `MODE_AVG` (acquire low): slow averaging. It runs only at mid-bit strobes while the loop reports lock.
- `MODE_CLAMP`: entered from `MODE_AVG` when acquire is high. Both estimates pull quickly toward the input.
- `MODE_LOSSY`: reached from `MODE_CLAMP` after the third mid-bit strobe while acquire stays high. New peaks are captured at once, and each estimate leaks slowly toward the midpoint.

Dropping acquire returns the block to `MODE_AVG` from either `MODE_CLAMP` or `MODE_LOSSY`. The system controller raises acquire when a burst is expected and lowers it once the preamble or frame sync has been found.

Top module: `peak_slicer`

## Requirements
- R1: After reset both peak estimates, the threshold and the output bit are 0, and the mode is `MODE_AVG`.
- R2: In `MODE_CLAMP`, each valid sample moves both estimates by (sample − estimate) arithmetically shifted right by 2.
- R3: `MODE_CLAMP` lasts exactly three mid-bit strobes, counted from its first cycle, and then becomes `MODE_LOSSY`. With one strobe per bit period, this gives between 2 and 3 bit times.
- R4: In `MODE_LOSSY`, a sample above the positive estimate replaces it, and a sample below the negative estimate replaces it. Otherwise each estimate moves toward the midpoint by (midpoint − estimate) arithmetically shifted right by 6, once per valid sample.
- R5: In `MODE_AVG`, the estimates change only at a mid-bit strobe with lock high. A decided 1 moves the positive estimate, and a decided 0 moves the negative estimate, by (sample − estimate) arithmetically shifted right by 8.
- R6: The base threshold is (positive + negative) arithmetically shifted right by 1.
- R7: When the last two decided bits are equal, the threshold is the base shifted toward the last bit's polarity: up for 1, down for 0. The shift is (positive − negative) arithmetically shifted right by 2 when `bt_sel`=0, or by 3 when `bt_sel`=1. Otherwise the threshold equals the base.
- R8: At a mid-bit strobe (`smp_vld` and `mid_stb` both high), the output bit becomes 1 if the sample is strictly greater than the threshold and 0 otherwise. The bit holds between strobes.
- R9: Without `smp_vld`, neither estimate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A new sample is present this cycle |
| smp_in | input | DW | Signed input sample |
| mid_stb | input | 1 | Mid-bit strobe; used only together with `smp_vld` |
| acq | input | 1 | Acquire control |
| pll_lock | input | 1 | Clock recovery loop reports lock |
| bt_sel | input | 1 | Filter bandwidth select: 0 = narrow, 1 = wide |
| rx_bit | output | 1 | Last decided bit |
| pk_pos | output | DW | Positive peak estimate |
| pk_neg | output | DW | Negative peak estimate |
| thresh | output | DW | Current decision threshold |

## Verification
The assertions assume that `mid_stb` matters only in a cycle where `smp_vld` is also high. They also assume that sample values stay well inside the signed range, so that sums of the peak estimates in the wider internal arithmetic do not wrap. The stimulus drives samples of at most about ±2000 on 12 bits. Acquire and the lock flag are changed only in idle cycles with no sample present, so each mode change can be separated cleanly from the sample updates around it.

// File: rtl/peak_slicer_pkg.sv
package peak_slicer_pkg;
    typedef enum logic [1:0] {
        MODE_AVG   = 2'd0,
        MODE_CLAMP = 2'd1,
        MODE_LOSSY = 2'd2
    } trk_mode_e;
endpackage

// File: rtl/pks_mode_fsm.sv
module pks_mode_fsm
    import peak_slicer_pkg::*;
#(
    parameter int CLAMP_BITS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acq,
    input  logic      bit_stb,
    output trk_mode_e mode
);
    localparam int CW = $clog2(CLAMP_BITS + 1);

    trk_mode_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    // state register and clamp strobe counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MODE_AVG;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != MODE_CLAMP)
                cnt_q <= '0;
            else if (bit_stb)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_AVG:   if (acq) st_d = MODE_CLAMP;
            MODE_CLAMP: begin
                if (!acq)
                    st_d = MODE_AVG;
                else if (bit_stb && (cnt_q == CW'(CLAMP_BITS - 1)))
                    st_d = MODE_LOSSY;
            end
            MODE_LOSSY: if (!acq) st_d = MODE_AVG;
            default:    st_d = MODE_AVG;
        endcase
    end

    // outputs
    always_comb begin
        mode = st_q;
    end
endmodule

// File: rtl/pks_peak_track.sv
module pks_peak_track
    import peak_slicer_pkg::*;
#(
    parameter int DW       = 12,
    parameter int CLAMP_SH = 2,
    parameter int LOSSY_SH = 6,
    parameter int AVG_SH   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  trk_mode_e            mode,
    input  logic                 smp_vld,
    input  logic                 bit_stb,
    input  logic                 pll_lock,
    input  logic                 dec_bit,
    input  logic signed [DW-1:0] smp_in,
    output logic signed [DW-1:0] pk_pos,
    output logic signed [DW-1:0] pk_neg
);
    localparam int WW = DW + 2;

    logic signed [WW-1:0] x_w, pos_w, neg_w, mid_w, pos_n, neg_n;

    assign x_w   = {{2{smp_in[DW-1]}}, smp_in};
    assign pos_w = {{2{pk_pos[DW-1]}}, pk_pos};
    assign neg_w = {{2{pk_neg[DW-1]}}, pk_neg};
    assign mid_w = (pos_w + neg_w) >>> 1;

    always_comb begin
        pos_n = pos_w;
        neg_n = neg_w;
        unique case (mode)
            MODE_CLAMP: begin
                pos_n = pos_w + ((x_w - pos_w) >>> CLAMP_SH);
                neg_n = neg_w + ((x_w - neg_w) >>> CLAMP_SH);
            end
            MODE_LOSSY: begin
                if (x_w > pos_w) pos_n = x_w;
                else             pos_n = pos_w - ((pos_w - mid_w) >>> LOSSY_SH);
                if (x_w < neg_w) neg_n = x_w;
                else             neg_n = neg_w + ((mid_w - neg_w) >>> LOSSY_SH);
            end
            MODE_AVG: begin
                if (bit_stb && pll_lock) begin
                    if (dec_bit) pos_n = pos_w + ((x_w - pos_w) >>> AVG_SH);
                    else         neg_n = neg_w + ((x_w - neg_w) >>> AVG_SH);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_pos <= '0;
            pk_neg <= '0;
        end else if (smp_vld) begin
            pk_pos <= pos_n[DW-1:0];
            pk_neg <= neg_n[DW-1:0];
        end
    end
endmodule

// File: rtl/pks_slicer.sv
module pks_slicer #(
    parameter int DW       = 12,
    parameter int ISI_SH_N = 2,
    parameter int ISI_SH_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bt_sel,
    input  logic signed [DW-1:0] smp_in,
    input  logic signed [DW-1:0] pk_pos,
    input  logic signed [DW-1:0] pk_neg,
    output logic signed [DW-1:0] thresh,
    output logic                 dec_bit,
    output logic                 rx_bit
);
    localparam int WW = DW + 2;

    logic [1:0] hist_q;
    logic signed [WW-1:0] x_w, pos_w, neg_w, base_w, p2p_w, isi_w, thr_w;

    assign x_w    = {{2{smp_in[DW-1]}}, smp_in};
    assign pos_w  = {{2{pk_pos[DW-1]}}, pk_pos};
    assign neg_w  = {{2{pk_neg[DW-1]}}, pk_neg};
    assign base_w = (pos_w + neg_w) >>> 1;
    assign p2p_w  = pos_w - neg_w;
    assign isi_w  = bt_sel ? (p2p_w >>> ISI_SH_W) : (p2p_w >>> ISI_SH_N);

    always_comb begin
        thr_w = base_w;
        if (hist_q[0] == hist_q[1])
            thr_w = hist_q[0] ? (base_w + isi_w) : (base_w - isi_w);
    end

    assign thresh  = thr_w[DW-1:0];
    assign dec_bit = (x_w > thr_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            rx_bit <= 1'b0;
        end else if (bit_stb) begin
            hist_q <= {hist_q[0], dec_bit};
            rx_bit <= dec_bit;
        end
    end
endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
    import peak_slicer_pkg::*;
#(
    parameter int DW         = 12,
    parameter int CLAMP_BITS = 3,
    parameter int CLAMP_SH   = 2,
    parameter int LOSSY_SH   = 6,
    parameter int AVG_SH     = 8,
    parameter int ISI_SH_N   = 2,
    parameter int ISI_SH_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_in,
    input  logic                 mid_stb,
    input  logic                 acq,
    input  logic                 pll_lock,
    input  logic                 bt_sel,
    output logic                 rx_bit,
    output logic signed [DW-1:0] pk_pos,
    output logic signed [DW-1:0] pk_neg,
    output logic signed [DW-1:0] thresh
);
    trk_mode_e mode;
    logic      bit_stb;
    logic      dec_bit;

    assign bit_stb = smp_vld & mid_stb;

    pks_mode_fsm #(.CLAMP_BITS(CLAMP_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acq(acq), .bit_stb(bit_stb), .mode(mode)
    );

    pks_peak_track #(
        .DW(DW), .CLAMP_SH(CLAMP_SH), .LOSSY_SH(LOSSY_SH), .AVG_SH(AVG_SH)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .mode(mode), .smp_vld(smp_vld),
        .bit_stb(bit_stb), .pll_lock(pll_lock), .dec_bit(dec_bit),
        .smp_in(smp_in), .pk_pos(pk_pos), .pk_neg(pk_neg)
    );

    pks_slicer #(.DW(DW), .ISI_SH_N(ISI_SH_N), .ISI_SH_W(ISI_SH_W)) u_slc (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bt_sel(bt_sel),
        .smp_in(smp_in), .pk_pos(pk_pos), .pk_neg(pk_neg),
        .thresh(thresh), .dec_bit(dec_bit), .rx_bit(rx_bit)
    );
endmodule

// File: rtl/peak_slicer_chk.sv
module peak_slicer_chk
    import peak_slicer_pkg::*;
#(
    parameter int DW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_vld,
    input logic                 mid_stb,
    input logic                 acq,
    input logic                 pll_lock,
    input logic signed [DW-1:0] smp_in,
    input logic signed [DW-1:0] pk_pos,
    input logic signed [DW-1:0] pk_neg,
    input logic                 rx_bit,
    input trk_mode_e            mode
);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(pk_pos) && $stable(pk_neg)));

    p_avg_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AVG && !pll_lock) |=> ($stable(pk_pos) && $stable(pk_neg)));

    p_avg_offstrobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AVG && !mid_stb) |=> ($stable(pk_pos) && $stable(pk_neg)));

    p_lossy_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOSSY && smp_vld && smp_in > pk_pos) |=> (pk_pos == $past(smp_in)));

    p_clamp_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AVG && acq) |=> (mode == MODE_CLAMP));

    p_acq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acq |=> (mode == MODE_AVG));

    p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && mid_stb) |=> $stable(rx_bit));
endmodule

bind peak_slicer peak_slicer_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mid_stb(mid_stb),
    .acq(acq), .pll_lock(pll_lock), .smp_in(smp_in), .pk_pos(pk_pos),
    .pk_neg(pk_neg), .rx_bit(rx_bit), .mode(mode)
);

// File: tb/tb_peak_slicer.sv
module tb_peak_slicer;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [DW-1:0] smp_in = '0;
    logic mid_stb = 1'b0;
    logic acq = 1'b0;
    logic pll_lock = 1'b0;
    logic bt_sel = 1'b0;
    logic rx_bit;
    logic signed [DW-1:0] pk_pos, pk_neg, thresh;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    peak_slicer dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .mid_stb(mid_stb), .acq(acq), .pll_lock(pll_lock), .bt_sel(bt_sel),
        .rx_bit(rx_bit), .pk_pos(pk_pos), .pk_neg(pk_neg), .thresh(thresh)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock with a sample (or idle when v=0); outputs sampled 1ns after the edge
    task automatic step(input bit v, input int x, input bit m);
        @(negedge clk);
        smp_vld = v;
        smp_in  = DW'(x);
        mid_stb = m;
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
        mid_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acq = 1'b0; pll_lock = 1'b0; bt_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        step(1'b0, 0, 1'b0);
        chk("R1 pos", int'(pk_pos), 0);
        chk("R1 neg", int'(pk_neg), 0);
        chk("R1 thr", int'(thresh), 0);
        chk("R1 bit", int'(rx_bit), 0);
    endtask

    // clamp pull, clamp length, then lossy capture and decay
    task automatic t_clamp_lossy();
        do_reset();
        acq = 1'b1;
        step(1'b0, 0, 1'b0);          // enter clamp
        step(1'b1, 0, 1'b1);          // strobe 1
        step(1'b1, 0, 1'b1);          // strobe 2
        step(1'b1, 800, 1'b0);
        chk("R2 clamp pos", int'(pk_pos), 200);
        chk("R2 clamp neg", int'(pk_neg), 200);
        chk("R3 still clamp after 2 strobes", int'(pk_pos), 200);
        step(1'b1, 0, 1'b1);          // strobe 3, last clamp update
        chk("R2 clamp pos down", int'(pk_pos), 150);
        step(1'b1, 800, 1'b0);
        chk("R3 lossy after 3 strobes", int'(pk_pos), 800);
        chk("R4 neg unchanged at midpoint", int'(pk_neg), 150);
        step(1'b1, 300, 1'b0);
        chk("R4 pos decay", int'(pk_pos), 795);
        chk("R4 neg decay", int'(pk_neg), 155);
        step(1'b1, -600, 1'b0);
        chk("R4 neg capture", int'(pk_neg), -600);
        chk("R4 pos decay 2", int'(pk_pos), 790);
        step(1'b0, 2000, 1'b0);
        chk("R9 idle no update", int'(pk_pos), 790);
    endtask

    // averaging: gated by lock, moves one estimate per strobe
    task automatic t_avg();
        acq = 1'b0;
        step(1'b0, 0, 1'b0);          // to averaging
        step(1'b1, 0, 1'b1);
        step(1'b1, 2000, 1'b1);
        chk("R5 unlocked pos hold", int'(pk_pos), 790);
        chk("R5 unlocked neg hold", int'(pk_neg), -600);
        pll_lock = 1'b1;
        step(1'b1, 2000, 1'b0);
        chk("R5 off-strobe hold", int'(pk_pos), 790);
        step(1'b1, 1302, 1'b1);
        chk("R5 avg pos", int'(pk_pos), 792);
        chk("R5 avg neg kept", int'(pk_neg), -600);
        chk("R8 bit one", int'(rx_bit), 1);
        step(1'b1, -1112, 1'b1);
        chk("R5 avg neg", int'(pk_neg), -602);
        chk("R8 bit zero", int'(rx_bit), 0);
    endtask

    // threshold midpoint, ISI offset, BT select, strict comparison
    task automatic t_isi();
        do_reset();
        acq = 1'b1;
        step(1'b0, 0, 1'b0);
        step(1'b1, 0, 1'b1);
        step(1'b1, 0, 1'b1);
        step(1'b1, 0, 1'b1);          // now lossy, history 0,0
        step(1'b1, 1000, 1'b0);
        step(1'b1, -1000, 1'b0);      // pos 993, neg -1000
        chk("R7 narrow offset down", int'(thresh), -502);
        bt_sel = 1'b1;
        #1;
        chk("R7 wide offset down", int'(thresh), -253);
        bt_sel = 1'b0;
        step(1'b1, -400, 1'b1);
        chk("R8 ISI-shifted decision", int'(rx_bit), 1);
        chk("R6 base threshold", int'(thresh), -4);
        step(1'b1, -4, 1'b1);
        chk("R8 equal gives zero", int'(rx_bit), 0);
    endtask

    initial begin
        t_reset();
        t_clamp_lossy();
        t_avg();
        t_isi();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule